// File: doc/BRIEF.md
# Truth-Table ALU with Accumulator and Branch Tests

This block is the arithmetic and logic core of a small accumulator machine. Each bit of the front end holds two 4:1 multiplexers, both selected by the pair formed from the accumulator bit and the second-operand bit. Their data inputs come from truth-table strobes. The first multiplexer drives the propagate operand of a single ripple adder. The second forms a generate term, which enters the adder shifted up one place. That split lets one adder produce logic functions, sums and differences, increments and decrements, and the fixed patterns all-zeros and all-ones. A 2:1 stage after the adder picks either the sum or a hardwired right-shifted copy of it.

The accumulator sits next to the adder and is updated from the result on a clock edge. Registered flags keep the outcome of the last compare (equal, less, greater), the last arithmetic carry and the last bit shifted out. The zero test has no reduction tree of its own. The negate operation presents the inverse of the accumulator with carry-in set, so the adder's carry-out is high exactly when the accumulator is zero. The accumulator sign bit supplies the sign test. Together these two drive a combinational branch-taken output for a selected condition. Instruction decode, the register file and memory are outside this block.

Top module: `muxalu`

## Requirements
- R1: The logic operations are combinational on `result`, with `carryOut` low: opCode 0 gives acc AND B, 1 gives acc OR B, 2 gives acc XOR B, and 3 gives the bitwise inverse of acc.
- R2: The arithmetic operations report `carryOut` as bit W of the true sum: opCode 4 gives acc+B, 5 gives acc+~B+1, so carryOut is 1 when no borrow occurs, 6 gives acc+1, and 7 gives acc plus all-ones.
- R3: opCode 10 passes B, opCode 11 gives all zeros, and opCode 12 gives all ones, each with carryOut 0. opCode 13 gives ~acc+1, and its carryOut is 1 exactly when acc is zero.
- R4: opCode 9 is a logical right shift of acc by one: result MSB is 0 and carryOut is 0. When it is executed, acc bit 0 is captured in `flagShift`.
- R5: opCode 8 compares acc against B as unsigned values. When executed, exactly one of `flagEq`, `flagLt`, `flagGt` is set according to the comparison, and acc keeps its value.
- R6: On a rising clock edge with `accLoad` high and opCode in 0..13 other than 8, acc takes the value `result` had before the edge. Otherwise acc holds.
- R7: Flags change only on an edge with `accLoad` high. `flagCarry` is updated by opCodes 4, 5, 6, 7 and 13. Compare flags change only on opCode 8 and `flagShift` only on opCode 9. All other flags keep their values.
- R8: `branchTaken` is combinational. condSel 0 (always) gives 1 for any opCode. With opCode 13, condSel 1 gives acc==0, condSel 2 gives acc MSB, and condSel 3 gives acc nonzero with MSB clear. For any other opCode, condSel 1..3 give 0.
- R9: While `rstN` is low, acc and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | Operation select, codes 0..13 |
| operandB | input | W | Second operand |
| accLoad | input | 1 | Execute enable for accumulator and flag updates |
| condSel | input | 2 | Branch condition: 0 always, 1 zero, 2 negative, 3 positive |
| result | output | W | Combinational ALU result |
| carryOut | output | 1 | Combinational adder carry-out |
| acc | output | W | Accumulator register |
| flagEq | output | 1 | Last compare: equal |
| flagLt | output | 1 | Last compare: acc below B |
| flagGt | output | 1 | Last compare: acc above B |
| flagCarry | output | 1 | Carry from last executed arithmetic operation |
| flagShift | output | 1 | Bit shifted out by last executed shift |
| branchTaken | output | 1 | Selected branch condition holds |

## Verification
The properties assume `opCode` stays within the defined codes 0..13. Codes 14 and 15 write nothing, and the stimulus never drives them. The zero and sign branch checks assume the caller issues opCode 13 in the cycle the decision is needed. The sweep does this for every accumulator value, cycling all four condition selects while the operation is held. The bench runs with a 4-bit width, so it covers every accumulator value, every operand and every defined operation, with the load enable toggled between steps.

// File: rtl/muxalu_pkg.sv
package muxalu_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_INV   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_INC   = 4'd6,
    OP_DEC   = 4'd7,
    OP_CMP   = 4'd8,
    OP_SHR   = 4'd9,
    OP_PASSB = 4'd10,
    OP_ZERO  = 4'd11,
    OP_ONES  = 4'd12,
    OP_NEG   = 4'd13
  } aluOp_e;

  typedef enum logic [1:0] {
    COND_ALWAYS = 2'd0,
    COND_ZERO   = 2'd1,
    COND_NEG    = 2'd2,
    COND_POS    = 2'd3
  } cond_e;

  // Truth tables are indexed by {accBit, bBit}.
  typedef struct packed {
    logic [3:0] pTruth;   // propagate operand table
    logic [3:0] gTruth;   // generate term table (enters adder shifted by one)
    logic       carryIn;
    logic       shiftSel;
    logic       zeroTest;
    logic       writeAcc;
    logic       cmpUpd;
    logic       carryUpd;
    logic       shiftUpd;
  } strobe_t;

  localparam logic [3:0] TT_ZERO  = 4'b0000;
  localparam logic [3:0] TT_AND   = 4'b1000;
  localparam logic [3:0] TT_OR    = 4'b1110;
  localparam logic [3:0] TT_XOR   = 4'b0110;
  localparam logic [3:0] TT_XNOR  = 4'b1001;
  localparam logic [3:0] TT_NOTA  = 4'b0011;
  localparam logic [3:0] TT_A     = 4'b1100;
  localparam logic [3:0] TT_B     = 4'b1010;
  localparam logic [3:0] TT_ANDNB = 4'b0100;
  localparam logic [3:0] TT_ONES  = 4'b1111;

endpackage

// File: rtl/muxalu_ctrl.sv
module muxalu_ctrl
  import muxalu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic       accLoad,
  output strobe_t    strobe
);

  logic [3:0] pTab;
  logic [3:0] gTab;
  logic       cin;
  logic       isShift;
  logic       isCmp;
  logic       isArith;
  logic       isNeg;
  logic       valid;

  always_comb begin
    pTab    = TT_ZERO;
    gTab    = TT_ZERO;
    cin     = 1'b0;
    isShift = 1'b0;
    isCmp   = 1'b0;
    isArith = 1'b0;
    isNeg   = 1'b0;
    valid   = 1'b1;
    case (aluOp_e'(opCode))
      OP_AND:   pTab = TT_AND;
      OP_OR:    pTab = TT_OR;
      OP_XOR:   pTab = TT_XOR;
      OP_INV:   pTab = TT_NOTA;
      OP_ADD: begin
        pTab = TT_XOR;  gTab = TT_AND;   isArith = 1'b1;
      end
      OP_SUB: begin
        pTab = TT_XNOR; gTab = TT_ANDNB; cin = 1'b1; isArith = 1'b1;
      end
      OP_INC: begin
        pTab = TT_A;    cin = 1'b1;      isArith = 1'b1;
      end
      OP_DEC: begin
        pTab = TT_NOTA; gTab = TT_A;     isArith = 1'b1;
      end
      OP_CMP: begin
        pTab = TT_XNOR; gTab = TT_ANDNB; cin = 1'b1; isCmp = 1'b1;
      end
      OP_SHR: begin
        pTab = TT_A;    isShift = 1'b1;
      end
      OP_PASSB: pTab = TT_B;
      OP_ZERO:  pTab = TT_ZERO;
      OP_ONES:  pTab = TT_ONES;
      OP_NEG: begin
        pTab = TT_NOTA; cin = 1'b1; isArith = 1'b1; isNeg = 1'b1;
      end
      default:  valid = 1'b0;
    endcase
  end

  always_comb begin
    strobe.pTruth   = pTab;
    strobe.gTruth   = gTab;
    strobe.carryIn  = cin;
    strobe.shiftSel = isShift;
    strobe.zeroTest = isNeg;
    strobe.writeAcc = accLoad & valid & ~isCmp;
    strobe.cmpUpd   = accLoad & isCmp;
    strobe.carryUpd = accLoad & isArith;
    strobe.shiftUpd = accLoad & isShift;
  end

endmodule

// File: rtl/muxalu_dp.sv
module muxalu_dp
  import muxalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strobe,
  input  logic [W-1:0] operandB,
  input  logic [1:0]   condSel,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic [W-1:0] acc,
  output logic         flagEq,
  output logic         flagLt,
  output logic         flagGt,
  output logic         flagCarry,
  output logic         flagShift,
  output logic         branchTaken
);

  localparam int MSB = W - 1;

  logic [W-1:0] pTerm;
  logic [W-1:0] gTerm;
  logic [W-1:0] qTerm;
  logic [W-1:0] sum;
  logic [W:0]   rip;

  // Per-bit truth-table front end.
  for (genvar i = 0; i < W; i++) begin : g_front
    assign pTerm[i] = strobe.pTruth[{acc[i], operandB[i]}];
    assign gTerm[i] = strobe.gTruth[{acc[i], operandB[i]}];
  end

  assign qTerm = {gTerm[MSB-1:0], 1'b0};

  // Ripple adder.
  assign rip[0] = strobe.carryIn;
  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign sum[i]   = pTerm[i] ^ qTerm[i] ^ rip[i];
    assign rip[i+1] = (pTerm[i] & qTerm[i]) | (rip[i] & (pTerm[i] ^ qTerm[i]));
  end

  // The top generate bit weighs 2^W and cannot coincide with a ripple carry.
  assign carryOut = rip[W] | gTerm[MSB];

  // Output stage: direct or hardwired shift by one.
  assign result = strobe.shiftSel ? {1'b0, sum[MSB:1]} : sum;

  logic diffZero;
  assign diffZero = ~|sum;

  // Branch decision: carry of the negate pattern means acc is zero.
  logic isZero;
  logic isNeg;
  assign isZero = strobe.zeroTest & carryOut;
  assign isNeg  = strobe.zeroTest & acc[MSB];

  always_comb begin
    case (cond_e'(condSel))
      COND_ALWAYS: branchTaken = 1'b1;
      COND_ZERO:   branchTaken = isZero;
      COND_NEG:    branchTaken = isNeg;
      default:     branchTaken = strobe.zeroTest & ~carryOut & ~acc[MSB];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      flagEq    <= 1'b0;
      flagLt    <= 1'b0;
      flagGt    <= 1'b0;
      flagCarry <= 1'b0;
      flagShift <= 1'b0;
    end else begin
      if (strobe.writeAcc) acc <= result;
      if (strobe.cmpUpd) begin
        flagEq <= diffZero;
        flagLt <= ~carryOut;
        flagGt <= carryOut & ~diffZero;
      end
      if (strobe.carryUpd) flagCarry <= carryOut;
      if (strobe.shiftUpd) flagShift <= acc[0];
    end
  end

endmodule

// File: rtl/muxalu.sv
module muxalu
  import muxalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [3:0]   opCode,
  input  logic [W-1:0] operandB,
  input  logic         accLoad,
  input  logic [1:0]   condSel,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic [W-1:0] acc,
  output logic         flagEq,
  output logic         flagLt,
  output logic         flagGt,
  output logic         flagCarry,
  output logic         flagShift,
  output logic         branchTaken
);

  strobe_t strobe;

  muxalu_ctrl u_ctrl (
    .opCode (opCode),
    .accLoad(accLoad),
    .strobe (strobe)
  );

  muxalu_dp #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .operandB   (operandB),
    .condSel    (condSel),
    .result     (result),
    .carryOut   (carryOut),
    .acc        (acc),
    .flagEq     (flagEq),
    .flagLt     (flagLt),
    .flagGt     (flagGt),
    .flagCarry  (flagCarry),
    .flagShift  (flagShift),
    .branchTaken(branchTaken)
  );

endmodule

// File: rtl/muxalu_chk.sv
module muxalu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic [3:0]   opCode,
  input logic         accLoad,
  input logic [1:0]   condSel,
  input logic [W-1:0] result,
  input logic [W-1:0] acc,
  input logic         flagEq,
  input logic         flagLt,
  input logic         flagGt,
  input logic         branchTaken
);

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accLoad || opCode == 4'd8 || opCode > 4'd13) |=> $stable(acc));

  // R6
  acc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accLoad && opCode != 4'd8 && opCode <= 4'd13) |=> acc == $past(result));

  // R5
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagEq, flagLt, flagGt}));

  // R4
  shr_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd9) |-> !result[W-1]);

  // R8
  branch_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 2'd0) |-> branchTaken);

  // R8
  zero_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd13 && condSel == 2'd1) |-> branchTaken == (acc == '0));

endmodule

bind muxalu muxalu_chk #(.W(W)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .opCode     (opCode),
  .accLoad    (accLoad),
  .condSel    (condSel),
  .result     (result),
  .acc        (acc),
  .flagEq     (flagEq),
  .flagLt     (flagLt),
  .flagGt     (flagGt),
  .branchTaken(branchTaken)
);

// File: tb/muxalu_test.sv
`timescale 1ns/1ps
module muxalu_test;
  localparam int W    = 4;
  localparam int N    = 1 << W;
  localparam int MASK = N - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] operandB = '0;
  logic         accLoad = 1'b0;
  logic [1:0]   condSel = '0;
  logic [W-1:0] result;
  logic         carryOut;
  logic [W-1:0] acc;
  logic         flagEq, flagLt, flagGt, flagCarry, flagShift;
  logic         branchTaken;

  muxalu #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .operandB(operandB),
    .accLoad(accLoad), .condSel(condSel), .result(result), .carryOut(carryOut),
    .acc(acc), .flagEq(flagEq), .flagLt(flagLt), .flagGt(flagGt),
    .flagCarry(flagCarry), .flagShift(flagShift), .branchTaken(branchTaken)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mAcc = 0, mEq = 0, mLt = 0, mGt = 0, mCarry = 0, mShift = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(int op);
    if (op <= 3) return "R1";
    if (op <= 7) return "R2";
    if (op == 8) return "R5";
    if (op == 9) return "R4";
    return "R3";
  endfunction

  task automatic checkRegs(string req);
    check(req, "acc", 32'(acc), 32'(mAcc));
    check(req, "flagEq", 32'(flagEq), 32'(mEq));
    check(req, "flagLt", 32'(flagLt), 32'(mLt));
    check(req, "flagGt", 32'(flagGt), 32'(mGt));
    check("R7", "flagCarry", 32'(flagCarry), 32'(mCarry));
    check(req, "flagShift", 32'(flagShift), 32'(mShift));
  endtask

  task automatic setAcc(int v);
    @(negedge clk);
    opCode = 4'd10; operandB = W'(v); accLoad = 1'b1;
    @(negedge clk);
    accLoad = 1'b0;
    mAcc = v;
    check("R6", "acc preload", 32'(acc), 32'(mAcc));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state while held and just after release
    checkRegs("R9");
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R9");

    for (int op = 0; op <= 13; op++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          int full, expRes, expC, ld;
          setAcc(a);
          case (op)
            0: full = a & b;
            1: full = a | b;
            2: full = a ^ b;
            3: full = (~a) & MASK;
            4: full = a + b;
            5: full = a + ((~b) & MASK) + 1;
            6: full = a + 1;
            7: full = a + MASK;
            8: full = a + ((~b) & MASK) + 1;
            9: full = a >> 1;
            10: full = b;
            11: full = 0;
            12: full = MASK;
            default: full = ((~a) & MASK) + 1;
          endcase
          expRes = full & MASK;
          expC = (full >> W) & 1;
          ld = (((a + b + op) % 3) != 0) ? 1 : 0;
          opCode = 4'(op); operandB = W'(b); accLoad = ld[0];
          condSel = 2'd0;
          #0.2;
          if (op != 8) check(reqOf(op), "result", 32'(result), 32'(expRes));
          check(reqOf(op), "carryOut", 32'(carryOut), 32'(expC));
          for (int cs = 0; cs < 4; cs++) begin
            int expB;
            condSel = 2'(cs);
            #0.2;
            if (cs == 0) expB = 1;
            else if (op != 13) expB = 0;
            else if (cs == 1) expB = (a == 0) ? 1 : 0;
            else if (cs == 2) expB = (a >> (W - 1)) & 1;
            else expB = (a != 0 && ((a >> (W - 1)) & 1) == 0) ? 1 : 0;
            check("R8", "branchTaken", 32'(branchTaken), 32'(expB));
          end
          @(negedge clk);
          accLoad = 1'b0;
          if (ld == 1) begin
            if (op != 8) mAcc = expRes;
            if (op == 8) begin
              mEq = (a == b) ? 1 : 0;
              mLt = (a < b) ? 1 : 0;
              mGt = (a > b) ? 1 : 0;
            end
            if (op == 4 || op == 5 || op == 6 || op == 7 || op == 13) mCarry = expC;
            if (op == 9) mShift = a & 1;
          end
          checkRegs((op == 8 || op == 9) ? reqOf(op) : "R6");
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule